// File: doc/BRIEF.md
# Ethernet Header Prepender for a 64-bit Stream

This block builds a complete Ethernet frame from two inputs. The first is a header record that carries a destination address, a source address and a type field, and it is accepted with its own valid/ready handshake. The second is a payload stream with byte enables, an end marker and an error/user flag. On a single output stream the block sends the 14 header bytes and then the payload bytes, using the same data width, byte enables, last and user signals as the payload.

Fourteen header bytes do not fill a whole number of 8-byte beats. After the first full header beat, every output beat therefore holds six bytes left over from the previous input beat (or from the header) and the two lowest bytes of the current payload beat. The byte enables of the final output beat are computed again. If the final payload beat holds more than two bytes, the block adds one trailing beat for the bytes that are left. Both sides may stall at any time. A new header is taken only after the previous frame has fully left the block.

Top module: `eth_hdr_prepend`

## Requirements
- R1: During and right after reset, the output valid and busy are low, the payload ready is low and the header ready is high.
- R2: The first output beat holds the six destination address bytes and then the two upper source address bytes. Each field goes out most significant byte first, and the lowest byte of a beat sits on data bits [7:0].
- R3: The second output beat holds the four remaining source bytes, the two type bytes (upper byte first) and payload bytes 0 and 1. Every later beat holds the six bytes carried over from the previous payload beat, in lanes 0 to 5, and the two lowest bytes of the new payload beat, in lanes 6 and 7.
- R4: The final payload beat may hold n valid bytes, with its byte enables set contiguously from bit 0. When n is 1 or 2, the output beat built from it carries last, and its byte enables have the low 6+n bits set.
- R5: When n is 3 to 8, the beat built from the final payload beat has all byte enables set and no last. It is followed by one extra beat that has last and the low n-2 byte-enable bits set.
- R6: Every output beat that is not the final beat of a frame has all eight byte enables set and last low.
- R7: The user flag of the final output beat equals the user flag of the final payload beat. The user flag is low on every other output beat, whatever the payload user flag was on earlier beats.
- R8: While output valid is high and output ready is low, data, byte enables, last and user stay unchanged. Frames come out byte-exact under any ready pattern, including three cycles stalled followed by one ready.
- R9: Cycles in which the payload source holds valid low in the middle of a frame do not change the frame content.
- R10: Header ready is high only while busy is low. Busy rises on the cycle after a header is accepted and stays high until the final output beat of that frame has been accepted.
- R11: Frames offered one after another come out complete and in the order they were offered.
- R12: Payload ready is low while the block is idle and during the cycle in which the first header beat is prepared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header record offered |
| hdr_ready | output | 1 | Header record taken (idle only) |
| hdr_dst | input | 48 | Destination address |
| hdr_src | input | 48 | Source address |
| hdr_type | input | 16 | Type field |
| pay_data | input | 64 | Payload data, byte 0 in bits [7:0] |
| pay_keep | input | 8 | Payload byte enables |
| pay_valid | input | 1 | Payload beat offered |
| pay_ready | output | 1 | Payload beat taken |
| pay_last | input | 1 | Final payload beat of the frame |
| pay_user | input | 1 | Payload user flag, significant on the final beat |
| frm_data | output | 64 | Frame data |
| frm_keep | output | 8 | Frame byte enables |
| frm_valid | output | 1 | Frame beat valid |
| frm_ready | input | 1 | Downstream accepts the beat |
| frm_last | output | 1 | Final beat of the frame |
| frm_user | output | 1 | User flag on the final beat |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach is the trailing extra beat while the output is stalled and the next header is already waiting. In that case the carried bytes, their byte enables and the stored user flag must survive several held cycles, and the waiting header must not be taken early. The stimulus reaches it by sweeping payload lengths across every remainder modulo eight, including lengths 1, 2, 3, 17, 32, 33 and 256. It offers each header immediately after the previous payload ends, and it combines random downstream ready, a fixed three-stalls-then-one-ready pattern and random source gaps. The expected byte stream, byte enables, beat count and user flag are computed in the bench from the header fields and payload bytes of each frame.

// File: rtl/ehp_pkg.sv
package ehp_pkg;

   // Frame builder sequencing
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HDR  = 3'd1,
      ST_PAY  = 3'd2,
      ST_TAIL = 3'd3,
      ST_DONE = 3'd4
   } ehp_state_e;

   // Source of the beat loaded into the output register
   typedef enum logic [1:0] {
      SEL_HDR  = 2'd0,
      SEL_MRG  = 2'd1,
      SEL_TAIL = 2'd2
   } ehp_sel_e;

endpackage

// File: rtl/ehp_hdr_pack.sv
// Orders the header fields into wire byte order: byte 0 in the lowest lanes,
// each field sent most significant byte first.
module ehp_hdr_pack #(
   parameter int MAC_W  = 48,
   parameter int TYPE_W = 16
) (
   input  logic [MAC_W-1:0]              dst,
   input  logic [MAC_W-1:0]              src,
   input  logic [TYPE_W-1:0]             etype,
   output logic [(2*MAC_W+TYPE_W)-1:0]   wire_hdr
);
   localparam int HDR_W     = 2*MAC_W + TYPE_W;
   localparam int HDR_BYTES = HDR_W / 8;

   logic [HDR_W-1:0] msb_first;
   assign msb_first = {dst, src, etype};

   for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
      assign wire_hdr[i*8 +: 8] = msb_first[(HDR_BYTES-1-i)*8 +: 8];
   end
endmodule

// File: rtl/ehp_merge.sv
// Combines the carried bytes with the low bytes of a payload beat and
// derives the next carry and the trailing beat.
module ehp_merge #(
   parameter int DATA_W = 64,
   parameter int LEAD_B = 6
) (
   input  logic [LEAD_B*8-1:0]  carry_data,
   input  logic [LEAD_B-1:0]    carry_keep,
   input  logic [DATA_W-1:0]    pay_data,
   input  logic [DATA_W/8-1:0]  pay_keep,
   output logic [DATA_W-1:0]    mrg_data,
   output logic [DATA_W/8-1:0]  mrg_keep,
   output logic                 mrg_tail,
   output logic [LEAD_B*8-1:0]  nxt_data,
   output logic [LEAD_B-1:0]    nxt_keep,
   output logic [DATA_W-1:0]    tail_data,
   output logic [DATA_W/8-1:0]  tail_keep
);
   localparam int KEEP_W = DATA_W / 8;
   localparam int NEW_B  = KEEP_W - LEAD_B;

   // lanes 0..LEAD_B-1 come from the carry, the rest from the new beat
   for (genvar k = 0; k < KEEP_W; k++) begin : g_lane
      if (k < LEAD_B) begin : g_old
         assign mrg_data[k*8 +: 8] = carry_data[k*8 +: 8];
         assign mrg_keep[k]        = 1'b1;
         assign tail_data[k*8 +: 8] = carry_data[k*8 +: 8];
         assign tail_keep[k]        = carry_keep[k];
      end else begin : g_new
         assign mrg_data[k*8 +: 8] = pay_data[(k-LEAD_B)*8 +: 8];
         assign mrg_keep[k]        = pay_keep[k-LEAD_B];
         assign tail_data[k*8 +: 8] = 8'h00;
         assign tail_keep[k]        = 1'b0;
      end
   end

   assign mrg_tail = pay_keep[NEW_B];
   assign nxt_data = pay_data[DATA_W-1 -: LEAD_B*8];
   assign nxt_keep = pay_keep[KEEP_W-1 -: LEAD_B];
endmodule

// File: rtl/ehp_ctrl.sv
module ehp_ctrl import ehp_pkg::*; #(
   parameter int HDR_BEATS = 1
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     hdr_valid,
   output logic     hdr_ready,
   input  logic     pay_valid,
   input  logic     pay_last,
   input  logic     pay_tail,
   output logic     pay_ready,
   input  logic     out_valid,
   input  logic     out_ready,
   output logic     ld_out,
   output ehp_sel_e sel,
   output logic     hdr_load,
   output logic     hdr_shift,
   output logic     pay_take,
   output logic     busy
);
   localparam int HCNT_W = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

   ehp_state_e        st, st_nxt;
   logic [HCNT_W-1:0] hcnt;
   logic              adv;

   assign adv       = !out_valid || out_ready;
   assign hdr_ready = (st == ST_IDLE);
   assign hdr_load  = hdr_valid && hdr_ready;
   assign pay_ready = (st == ST_PAY) && adv;
   assign pay_take  = pay_valid && pay_ready;
   assign hdr_shift = (st == ST_HDR) && adv;
   assign ld_out    = hdr_shift || pay_take || ((st == ST_TAIL) && adv);
   assign busy      = (st != ST_IDLE);

   always_comb begin
      case (st)
         ST_HDR:  sel = SEL_HDR;
         ST_TAIL: sel = SEL_TAIL;
         default: sel = SEL_MRG;
      endcase
   end

   always_comb begin
      st_nxt = st;
      case (st)
         ST_IDLE: if (hdr_load) st_nxt = ST_HDR;
         ST_HDR:  if (adv && hcnt == '0) st_nxt = ST_PAY;
         ST_PAY:  if (pay_take && pay_last) st_nxt = pay_tail ? ST_TAIL : ST_DONE;
         ST_TAIL: if (adv) st_nxt = ST_DONE;
         ST_DONE: if (out_ready) st_nxt = ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_IDLE;
         hcnt <= '0;
      end else begin
         st <= st_nxt;
         if (hdr_load) begin
            hcnt <= HCNT_W'(HDR_BEATS - 1);
         end else if (hdr_shift && hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ehp_dpath.sv
module ehp_dpath import ehp_pkg::*; #(
   parameter int DATA_W    = 64,
   parameter int HDR_BYTES = 14
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  hdr_load,
   input  logic [HDR_BYTES*8-1:0] hdr_wire,
   input  logic                  hdr_shift,
   input  logic                  pay_take,
   input  logic [DATA_W-1:0]     pay_data,
   input  logic [DATA_W/8-1:0]   pay_keep,
   input  logic                  pay_last,
   input  logic                  pay_user,
   input  ehp_sel_e              sel,
   output logic [DATA_W-1:0]     ld_data,
   output logic [DATA_W/8-1:0]   ld_keep,
   output logic                  ld_last,
   output logic                  ld_user
);
   localparam int KEEP_W    = DATA_W / 8;
   localparam int LEAD_B    = HDR_BYTES % KEEP_W;
   localparam int HDR_BEATS = HDR_BYTES / KEEP_W;
   localparam int HSH_W     = HDR_BEATS * DATA_W;

   logic [HSH_W-1:0]     hsh;
   logic [LEAD_B*8-1:0]  carry_data;
   logic [LEAD_B-1:0]    carry_keep;
   logic                 tail_user;

   logic [DATA_W-1:0]    mrg_data, tail_data;
   logic [KEEP_W-1:0]    mrg_keep, tail_keep;
   logic                 mrg_tail;
   logic [LEAD_B*8-1:0]  nxt_data;
   logic [LEAD_B-1:0]    nxt_keep;
   logic                 mrg_end;

   ehp_merge #(.DATA_W(DATA_W), .LEAD_B(LEAD_B)) i_merge (
      .carry_data (carry_data),
      .carry_keep (carry_keep),
      .pay_data   (pay_data),
      .pay_keep   (pay_keep),
      .mrg_data   (mrg_data),
      .mrg_keep   (mrg_keep),
      .mrg_tail   (mrg_tail),
      .nxt_data   (nxt_data),
      .nxt_keep   (nxt_keep),
      .tail_data  (tail_data),
      .tail_keep  (tail_keep)
   );

   // header beat shifter: one variant per header beat count
   if (HDR_BEATS == 1) begin : g_hsh_one
      always_ff @(posedge clk) begin
         if (rst)            hsh <= '0;
         else if (hdr_load)  hsh <= hdr_wire[HSH_W-1:0];
         else if (hdr_shift) hsh <= '0;
      end
   end else begin : g_hsh_many
      always_ff @(posedge clk) begin
         if (rst)            hsh <= '0;
         else if (hdr_load)  hsh <= hdr_wire[HSH_W-1:0];
         else if (hdr_shift) hsh <= {{DATA_W{1'b0}}, hsh[HSH_W-1:DATA_W]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         carry_data <= '0;
         carry_keep <= '0;
         tail_user  <= 1'b0;
      end else if (hdr_load) begin
         carry_data <= hdr_wire[HDR_BYTES*8-1 -: LEAD_B*8];
         carry_keep <= '1;
      end else if (pay_take) begin
         carry_data <= nxt_data;
         carry_keep <= nxt_keep;
         tail_user  <= pay_user;
      end
   end

   assign mrg_end = pay_last && !mrg_tail;

   always_comb begin
      case (sel)
         SEL_MRG: begin
            ld_data = mrg_data;
            ld_keep = mrg_keep;
            ld_last = mrg_end;
            ld_user = mrg_end && pay_user;
         end
         SEL_TAIL: begin
            ld_data = tail_data;
            ld_keep = tail_keep;
            ld_last = 1'b1;
            ld_user = tail_user;
         end
         default: begin
            ld_data = hsh[DATA_W-1:0];
            ld_keep = '1;
            ld_last = 1'b0;
            ld_user = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/ehp_obuf.sv
module ehp_obuf #(
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld,
   input  logic [DATA_W-1:0]   ld_data,
   input  logic [DATA_W/8-1:0] ld_keep,
   input  logic                ld_last,
   input  logic                ld_user,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic [DATA_W/8-1:0] out_keep,
   output logic                out_valid,
   output logic                out_last,
   output logic                out_user
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_keep  <= '0;
         out_last  <= 1'b0;
         out_user  <= 1'b0;
      end else if (ld) begin
         out_valid <= 1'b1;
         out_data  <= ld_data;
         out_keep  <= ld_keep;
         out_last  <= ld_last;
         out_user  <= ld_user;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/eth_hdr_prepend.sv
module eth_hdr_prepend import ehp_pkg::*; #(
   parameter int DATA_W = 64,
   parameter int MAC_W  = 48,
   parameter int TYPE_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hdr_valid,
   output logic                hdr_ready,
   input  logic [MAC_W-1:0]    hdr_dst,
   input  logic [MAC_W-1:0]    hdr_src,
   input  logic [TYPE_W-1:0]   hdr_type,
   input  logic [DATA_W-1:0]   pay_data,
   input  logic [DATA_W/8-1:0] pay_keep,
   input  logic                pay_valid,
   output logic                pay_ready,
   input  logic                pay_last,
   input  logic                pay_user,
   output logic [DATA_W-1:0]   frm_data,
   output logic [DATA_W/8-1:0] frm_keep,
   output logic                frm_valid,
   input  logic                frm_ready,
   output logic                frm_last,
   output logic                frm_user,
   output logic                busy
);
   localparam int KEEP_W    = DATA_W / 8;
   localparam int HDR_BYTES = (2*MAC_W + TYPE_W) / 8;
   localparam int LEAD_B    = HDR_BYTES % KEEP_W;
   localparam int NEW_B     = KEEP_W - LEAD_B;
   localparam int HDR_BEATS = HDR_BYTES / KEEP_W;

   if (DATA_W % 8 != 0 || MAC_W % 8 != 0 || TYPE_W % 8 != 0) begin : g_chk_bytes
      $error("eth_hdr_prepend: widths must be whole bytes");
   end
   if (LEAD_B == 0) begin : g_chk_lead
      $error("eth_hdr_prepend: header must not fill whole beats");
   end
   if (HDR_BEATS < 1) begin : g_chk_beats
      $error("eth_hdr_prepend: header must span at least one full beat");
   end

   logic [HDR_BYTES*8-1:0] hdr_wire;
   logic                   ld_out, hdr_load, hdr_shift, pay_take;
   ehp_sel_e               sel;
   logic [DATA_W-1:0]      ld_data;
   logic [KEEP_W-1:0]      ld_keep;
   logic                   ld_last, ld_user;

   ehp_hdr_pack #(.MAC_W(MAC_W), .TYPE_W(TYPE_W)) i_pack (
      .dst      (hdr_dst),
      .src      (hdr_src),
      .etype    (hdr_type),
      .wire_hdr (hdr_wire)
   );

   ehp_ctrl #(.HDR_BEATS(HDR_BEATS)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .hdr_valid (hdr_valid),
      .hdr_ready (hdr_ready),
      .pay_valid (pay_valid),
      .pay_last  (pay_last),
      .pay_tail  (pay_keep[NEW_B]),
      .pay_ready (pay_ready),
      .out_valid (frm_valid),
      .out_ready (frm_ready),
      .ld_out    (ld_out),
      .sel       (sel),
      .hdr_load  (hdr_load),
      .hdr_shift (hdr_shift),
      .pay_take  (pay_take),
      .busy      (busy)
   );

   ehp_dpath #(.DATA_W(DATA_W), .HDR_BYTES(HDR_BYTES)) i_dpath (
      .clk       (clk),
      .rst       (rst),
      .hdr_load  (hdr_load),
      .hdr_wire  (hdr_wire),
      .hdr_shift (hdr_shift),
      .pay_take  (pay_take),
      .pay_data  (pay_data),
      .pay_keep  (pay_keep),
      .pay_last  (pay_last),
      .pay_user  (pay_user),
      .sel       (sel),
      .ld_data   (ld_data),
      .ld_keep   (ld_keep),
      .ld_last   (ld_last),
      .ld_user   (ld_user)
   );

   ehp_obuf #(.DATA_W(DATA_W)) i_obuf (
      .clk       (clk),
      .rst       (rst),
      .ld        (ld_out),
      .ld_data   (ld_data),
      .ld_keep   (ld_keep),
      .ld_last   (ld_last),
      .ld_user   (ld_user),
      .out_ready (frm_ready),
      .out_data  (frm_data),
      .out_keep  (frm_keep),
      .out_valid (frm_valid),
      .out_last  (frm_last),
      .out_user  (frm_user)
   );
endmodule

// File: rtl/ehp_chk.sv
module ehp_chk #(
   parameter int DATA_W = 64
) (
   input logic                clk,
   input logic                rst,
   input logic                hdr_valid,
   input logic                hdr_ready,
   input logic                pay_ready,
   input logic [DATA_W-1:0]   frm_data,
   input logic [DATA_W/8-1:0] frm_keep,
   input logic                frm_valid,
   input logic                frm_ready,
   input logic                frm_last,
   input logic                frm_user,
   input logic                busy
);
   // R8
   hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
      frm_valid && !frm_ready |=> frm_valid && $stable(frm_data) && $stable(frm_keep)
                                  && $stable(frm_last) && $stable(frm_user));
   // R10
   hdr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      hdr_ready |-> !busy);
   // R10
   hdr_busy_chk: assert property (@(posedge clk) disable iff (rst)
      hdr_valid && hdr_ready |=> busy);
   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(frm_valid && frm_ready && frm_last));
   // R12
   pay_gate_chk: assert property (@(posedge clk) disable iff (rst)
      pay_ready |-> busy);
   // R6
   full_keep_chk: assert property (@(posedge clk) disable iff (rst)
      frm_valid && !frm_last |-> &frm_keep);
   // R7
   user_last_chk: assert property (@(posedge clk) disable iff (rst)
      frm_valid && frm_user |-> frm_last);
   // R4
   keep_shape_chk: assert property (@(posedge clk) disable iff (rst)
      frm_valid |-> frm_keep[0] && ((frm_keep & (frm_keep + 1'b1)) == '0));
endmodule

bind eth_hdr_prepend ehp_chk #(.DATA_W(DATA_W)) i_ehp_chk (
   .clk       (clk),
   .rst       (rst),
   .hdr_valid (hdr_valid),
   .hdr_ready (hdr_ready),
   .pay_ready (pay_ready),
   .frm_data  (frm_data),
   .frm_keep  (frm_keep),
   .frm_valid (frm_valid),
   .frm_ready (frm_ready),
   .frm_last  (frm_last),
   .frm_user  (frm_user),
   .busy      (busy)
);

// File: tb/test_eth_hdr_prepend.sv
module test_eth_hdr_prepend;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 64;
   localparam int KEEP_W     = 8;
   localparam int HDR_BYTES  = 14;

   logic              clk, rst;
   logic              hdr_valid, hdr_ready;
   logic [47:0]       hdr_dst, hdr_src;
   logic [15:0]       hdr_type;
   logic [DATA_W-1:0] pay_data;
   logic [KEEP_W-1:0] pay_keep;
   logic              pay_valid, pay_ready, pay_last, pay_user;
   logic [DATA_W-1:0] frm_data;
   logic [KEEP_W-1:0] frm_keep;
   logic              frm_valid, frm_ready, frm_last, frm_user, busy;

   eth_hdr_prepend #(.DATA_W(DATA_W)) i_eth_hdr_prepend (
      .clk(clk), .rst(rst),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_dst(hdr_dst), .hdr_src(hdr_src), .hdr_type(hdr_type),
      .pay_data(pay_data), .pay_keep(pay_keep), .pay_valid(pay_valid),
      .pay_ready(pay_ready), .pay_last(pay_last), .pay_user(pay_user),
      .frm_data(frm_data), .frm_keep(frm_keep), .frm_valid(frm_valid),
      .frm_ready(frm_ready), .frm_last(frm_last), .frm_user(frm_user),
      .busy(busy)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;
   int          frames_tx = 0;
   int          frames_rx = 0;
   int          sink_mode = 0;
   bit          src_stall = 0;
   byte unsigned exp_q[$];
   int          len_q[$];
   bit          usr_q[$];
   string       tag_q[$];

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // expected byte enables of a frame's final beat
   function automatic logic [7:0] last_keep(int len);
      int rem;
      rem = (HDR_BYTES + len) % 8;
      return (rem == 0) ? 8'hFF : 8'((1 << rem) - 1);
   endfunction

   // downstream ready patterns
   initial begin
      int scnt = 0;
      frm_ready = 1'b0;
      forever begin
         @(posedge clk); #1;
         case (sink_mode)
            0: frm_ready = 1'b1;
            1: frm_ready = 1'($urandom_range(0, 1));
            default: begin
               frm_ready = (scnt == 3);
               scnt = (scnt + 1) % 4;
            end
         endcase
      end
   end

   // output monitor
   int          bi = 0, cur_len = 0, e0 = 0;
   bit          cur_usr = 0;
   string       cur_tag = "R11";
   bit          prev_stall = 0;
   logic [63:0] pd;
   logic [7:0]  pk;
   logic        pl, pu;

   always @(negedge clk) begin
      if (!rst && !finished) begin
         chk(!(hdr_ready && busy), "R10", "hdr_ready with busy", {hdr_ready, busy}, 2'b00);
         if (hdr_ready) chk(!pay_ready, "R12", "pay_ready while idle", pay_ready, 0);
         if (prev_stall)
            chk(frm_valid && frm_data == pd && frm_keep == pk && frm_last == pl && frm_user == pu,
                "R8", "held beat changed", frm_data, pd);
         if (frm_valid && frm_ready) begin
            int total, nb, n, rem0;
            bit lastx;
            logic [7:0]  kexp;
            logic [63:0] ew, m;
            string ltag;
            if (bi == 0) begin
               if (len_q.size() == 0) begin
                  chk(0, "R11", "beat without frame", frm_data, 0);
                  cur_len = 1; cur_usr = 0; cur_tag = "R11";
               end else begin
                  cur_len = len_q.pop_front();
                  cur_usr = usr_q.pop_front();
                  cur_tag = tag_q.pop_front();
               end
               e0 = errors;
            end
            total = HDR_BYTES + cur_len;
            nb    = (total + 7) / 8;
            lastx = (bi == nb - 1);
            rem0  = total % 8;
            kexp  = lastx ? last_keep(cur_len) : 8'hFF;
            n     = ((cur_len - 1) % 8) + 1;
            ltag  = lastx ? ((n <= 2) ? "R4" : "R5") : "R6";
            chk(frm_keep == kexp, ltag, "keep", frm_keep, kexp);
            chk(frm_last == lastx, ltag, "last", frm_last, lastx);
            ew = '0; m = '0;
            for (int k = 0; k < 8; k++) begin
               if (kexp[k]) begin
                  ew[k*8 +: 8] = exp_q.pop_front();
                  m[k*8 +: 8]  = 8'hFF;
               end
            end
            chk((frm_data & m) == ew, (bi == 0) ? "R2" : "R3", "data", frm_data & m, ew);
            chk(frm_user == (lastx && cur_usr), "R7", "user", frm_user, lastx && cur_usr);
            if (lastx) begin
               chk(errors == e0, cur_tag, "frame intact", errors - e0, 0);
               chk(!hdr_ready && busy, "R10", "state at final beat", {hdr_ready, busy}, 2'b01);
               frames_rx++;
               bi = 0;
            end else begin
               bi++;
            end
            if (rem0 < 0) bi = 0;
         end
         prev_stall = frm_valid && !frm_ready;
         pd = frm_data; pk = frm_keep; pl = frm_last; pu = frm_user;
      end
   end

   task automatic send_frame(int len, bit usr);
      logic [47:0] d, s;
      logic [15:0] t;
      byte unsigned pl_b[];
      int nbeats;
      d = {16'($urandom), 32'($urandom)};
      s = {16'($urandom), 32'($urandom)};
      t = 16'($urandom);
      pl_b = new[len];
      foreach (pl_b[i]) pl_b[i] = 8'($urandom);
      for (int i = 0; i < 6; i++) exp_q.push_back(d[47-8*i -: 8]);
      for (int i = 0; i < 6; i++) exp_q.push_back(s[47-8*i -: 8]);
      exp_q.push_back(t[15:8]);
      exp_q.push_back(t[7:0]);
      foreach (pl_b[i]) exp_q.push_back(pl_b[i]);
      len_q.push_back(len);
      usr_q.push_back(usr);
      tag_q.push_back(src_stall ? "R9" : ((sink_mode != 0) ? "R8" : "R11"));
      frames_tx++;

      hdr_dst = d; hdr_src = s; hdr_type = t; hdr_valid = 1'b1;
      forever begin @(negedge clk); if (hdr_ready) break; end
      @(posedge clk); #1;
      hdr_valid = 1'b0;
      hdr_dst = {16'($urandom), 32'($urandom)};
      hdr_src = {16'($urandom), 32'($urandom)};
      hdr_type = 16'($urandom);
      @(negedge clk);
      chk(!pay_ready, "R12", "pay_ready during header beat", pay_ready, 0);
      @(posedge clk); #1;

      nbeats = (len + 7) / 8;
      for (int b = 0; b < nbeats; b++) begin
         bit lb;
         if (src_stall) begin
            repeat ($urandom_range(0, 2)) begin
               pay_valid = 1'b0;
               pay_data  = {$urandom, $urandom};
               @(posedge clk); #1;
            end
         end
         lb = (b == nbeats - 1);
         for (int k = 0; k < 8; k++) begin
            int idx;
            idx = b*8 + k;
            pay_data[k*8 +: 8] = (idx < len) ? pl_b[idx] : 8'($urandom);
            pay_keep[k]        = (idx < len);
         end
         pay_last  = lb;
         pay_user  = lb ? usr : 1'($urandom_range(0, 1));
         pay_valid = 1'b1;
         forever begin @(negedge clk); if (pay_ready) break; end
         @(posedge clk); #1;
      end
      pay_valid = 1'b0;
      pay_last  = 1'b0;
      pay_user  = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      finished = 1;
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog expired: actual %0d frames expected %0d frames", frames_rx, frames_tx);
         finish_run();
      end
   end

   initial begin
      int dir_a[] = '{1, 2, 3, 8, 17, 32, 33, 256, 9, 10, 11, 16};
      int dir_b[] = '{17, 33, 32, 256};
      void'($urandom(32'h5EED_0A1B));
      rst = 1'b1;
      hdr_valid = 0; hdr_dst = '0; hdr_src = '0; hdr_type = '0;
      pay_data = '0; pay_keep = '0; pay_valid = 0; pay_last = 0; pay_user = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(!frm_valid && !busy && hdr_ready && !pay_ready, "R1", "state in reset",
          {frm_valid, busy, hdr_ready, pay_ready}, 4'b0010);
      @(posedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      // R1 after reset
      chk(!frm_valid, "R1", "frm_valid after reset", frm_valid, 0);
      chk(!busy && hdr_ready && !pay_ready, "R1", "handshakes after reset",
          {busy, hdr_ready, pay_ready}, 3'b010);
      @(posedge clk); #1;

      // directed lengths, free flow, back to back
      foreach (dir_a[i]) send_frame(dir_a[i], i[0]);
      // random downstream ready
      sink_mode = 1;
      foreach (dir_b[i]) send_frame(dir_b[i], 1'b1);
      for (int i = 0; i < 10; i++) send_frame($urandom_range(1, 70), 1'($urandom_range(0, 1)));
      // three stalled, one ready
      sink_mode = 2;
      foreach (dir_b[i]) send_frame(dir_b[i], i[0]);
      for (int i = 0; i < 8; i++) send_frame($urandom_range(1, 70), 1'($urandom_range(0, 1)));
      // source gaps
      sink_mode = 0; src_stall = 1;
      foreach (dir_b[i]) send_frame(dir_b[i], 1'b1);
      for (int i = 0; i < 8; i++) send_frame($urandom_range(1, 70), 1'($urandom_range(0, 1)));
      // both sides stalling
      sink_mode = 1;
      for (int i = 0; i < 12; i++) send_frame($urandom_range(1, 90), 1'($urandom_range(0, 1)));
      sink_mode = 2;
      send_frame(3, 1'b1);
      send_frame(2, 1'b1);

      for (int w = 0; w < 5000; w++) begin
         if (frames_rx == frames_tx) break;
         @(posedge clk);
      end
      #1;
      chk(frames_rx == frames_tx, "R11", "frames received", frames_rx, frames_tx);
      chk(exp_q.size() == 0, "R11", "bytes left over", exp_q.size(), 0);
      finish_run();
   end
endmodule